// File: doc/BRIEF.md
# Half-Bridge Adaptive Dead-Time Sequencer

This block converts one decoded PWM command into two gate enables for a synchronous buck half-bridge: one for the high-side switch and one for the low-side switch. It does not insert a fixed programmed dead time. Instead, it waits for digitized feedback from comparators that sense the power stage. Before it turns on the high side, it waits for a low-gate-discharged flag and then counts a short fixed delay. Before it turns on the low side, it waits for either a high-gate-discharged flag or a switch-node-low flag. If a wait runs too long, a watchdog ends it and the block latches a fault.

The block also tracks the supply. A rising-threshold flag brings the supply up and a falling-threshold flag takes it down, which gives hysteresis. Until the supply has come up for the first time after reset, the block requests a protective clamp that ties the low-side gate to the switch node, and it keeps the high side off. An input qualifier can also report a shutdown state, and both enables stay low for as long as that state lasts.

Top module: `hb_deadtime_seq`

## Requirements
- R1: `hi_gate_en` and `lo_gate_en` are never both 1 in the same cycle, under any input sequence.
- R2: Behaviour when `cmd_high` rises to 1 (with `cmd_off` = 0):
  - `lo_gate_en` falls after the first clock edge that samples the new command.
  - `hi_gate_en` stays 0 while `lg_low_fb` = 0.
- R3: `hi_gate_en` rises on the (DLY_CYC+1)-th clock edge, counting from the edge that first samples `lg_low_fb` = 1 during a rising-command wait.
- R4: Behaviour when `cmd_high` falls to 0:
  - `hi_gate_en` falls after the first edge that samples it.
  - `lo_gate_en` rises on the edge after `hg_low_fb` = 1 or `sw_low_fb` = 1 is sampled during the wait.
  - Either flag alone is enough.
- R5: After reset, until the supply has come up for the first time:
  - `pre_clamp` = 1.
  - `hi_gate_en` = 0.
- R6: Supply hysteresis:
  - `sup_rise` = 1 brings the supply up.
  - `sup_fall` = 1 takes it down, and wins if both flags are 1 in the same cycle.
  - The gates follow the command again once the supply is back up.
- R7: Behaviour after the supply goes down:
  - Both enables are 0 from the second edge after `sup_fall` is sampled.
  - `pre_clamp` stays 0 until the next reset, even if the supply later comes back up.
- R8: While `cmd_off` = 1, both enables are 0 from the edge after it is sampled. On release, the normal feedback-gated sequence resumes.
- R9: If the command reverses while a wait or the delay is pending, the pending turn-on is cancelled and the sequence restarts in the new direction. No enable asserts early.
- R10: Watchdog on feedback waits:
  - A wait that sees no feedback for WD_CYC edges sets `wd_fault` = 1.
  - `wd_fault` stays 1 until reset, and both enables are held at 0 while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_high | input | 1 | Decoded PWM command: 1 requests the high side, 0 requests the low side |
| cmd_off | input | 1 | Qualifier shutdown state; overrides `cmd_high` |
| sup_rise | input | 1 | Supply is above the rising threshold |
| sup_fall | input | 1 | Supply is below the falling threshold |
| lg_low_fb | input | 1 | Low-side gate has discharged |
| hg_low_fb | input | 1 | High-side gate-to-switch-node voltage has discharged |
| sw_low_fb | input | 1 | Switch node is below its threshold |
| hi_gate_en | output | 1 | High-side gate enable |
| lo_gate_en | output | 1 | Low-side gate enable |
| pre_clamp | output | 1 | Request to tie the low-side gate to the switch node |
| wd_fault | output | 1 | Sticky watchdog fault |

## Verification
The assertions check the following on every cycle:
- the two enables never overlap;
- each enable rises only when the other was low on the previous cycle and the command pointed its way;
- shutdown, a supply drop or a latched fault force both enables low;
- the fault stays latched and the clamp never re-arms.

Only the bench scenarios can show the rest:
- the exact delay count;
- that either low-side release flag is enough on its own;
- cancellation of a pending turn-on inside the delay;
- the watchdog window length;
- recovery after the supply comes back.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_LS   = 3'd1,
    ST_WLG  = 3'd2,
    ST_DLY  = 3'd3,
    ST_HS   = 3'd4,
    ST_WHG  = 3'd5,
    ST_SHUT = 3'd6,
    ST_FLT  = 3'd7
  } hb_state_e;

  function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

  // true on the last cycle of a window of lim cycles
  function automatic logic at_limit(int unsigned cnt, int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

endpackage

// File: rtl/hbd_supply_por.sv
module hbd_supply_por (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic fall_i,
  output logic up_o,
  output logic clamp_o
);
  logic up_d;
  logic seen_q;

  always_comb begin
    if (fall_i)      up_d = 1'b0;
    else if (rise_i) up_d = 1'b1;
    else             up_d = up_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_o   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      up_o   <= up_d;
      seen_q <= seen_q | up_d;
    end
  end

  assign clamp_o = ~seen_q;

  // R6
  fall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_i |=> !up_o);
  // R6
  rise_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !fall_i) |=> up_o);
  // R7
  clamp_no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(clamp_o));
  // R5
  clamp_until_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_o |-> !clamp_o);

endmodule

// File: rtl/hbd_step_timer.sv
module hbd_step_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_o <= '0;
    else if (clr_i)          cnt_o <= '0;
    else if (cnt_o != CMAX)  cnt_o <= cnt_o + ONE;
  end

endmodule

// File: rtl/hbd_gate_seq.sv
module hbd_gate_seq
  import hbd_pkg::*;
#(
  parameter int DLY_CYC = 2,
  parameter int WD_CYC  = 64,
  parameter int CW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_i,
  input  logic          pwm_hi_i,
  input  logic          pwm_off_i,
  input  logic          lg_low_i,
  input  logic          hg_low_i,
  input  logic          sw_low_i,
  input  logic [CW-1:0] cnt_i,
  output logic          clr_o,
  output logic          hs_en_o,
  output logic          ls_en_o,
  output logic          fault_o
);
  hb_state_e state_q, state_d;

  // named events for checks
  logic lo_confirm, hi_confirm, dly_done, wd_expire;
  assign lo_confirm = lg_low_i;
  assign hi_confirm = hg_low_i | sw_low_i;
  assign dly_done   = at_limit(32'(cnt_i), DLY_CYC);
  assign wd_expire  = at_limit(32'(cnt_i), WD_CYC);

  always_comb begin
    state_d = state_q;
    if (state_q == ST_FLT)  state_d = ST_FLT;
    else if (!up_i)         state_d = ST_OFF;
    else if (pwm_off_i)     state_d = ST_SHUT;
    else begin
      unique case (state_q)
        ST_OFF, ST_SHUT: state_d = pwm_hi_i ? ST_WLG : ST_WHG;
        ST_LS:  if (pwm_hi_i) state_d = ST_WLG;
        ST_HS:  if (!pwm_hi_i) state_d = ST_WHG;
        ST_WLG: begin
          if (!pwm_hi_i)       state_d = ST_WHG;
          else if (lo_confirm) state_d = ST_DLY;
          else if (wd_expire)  state_d = ST_FLT;
        end
        ST_DLY: begin
          if (!pwm_hi_i)     state_d = ST_WHG;
          else if (dly_done) state_d = ST_HS;
        end
        ST_WHG: begin
          if (pwm_hi_i)        state_d = ST_WLG;
          else if (hi_confirm) state_d = ST_LS;
          else if (wd_expire)  state_d = ST_FLT;
        end
        default: state_d = ST_FLT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign clr_o   = (state_d != state_q);
  assign hs_en_o = (state_q == ST_HS);
  assign ls_en_o = (state_q == ST_LS);
  assign fault_o = (state_q == ST_FLT);

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en_o && ls_en_o));
  // R2
  hs_after_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en_o) |-> (!$past(ls_en_o) && $past(pwm_hi_i)));
  // R4
  ls_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en_o) |-> (!$past(hs_en_o) && !$past(pwm_hi_i)));
  // R8
  shut_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_off_i |=> (!hs_en_o && !ls_en_o));
  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);
  // R10
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!hs_en_o && !ls_en_o));

endmodule

// File: rtl/hb_deadtime_seq.sv
module hb_deadtime_seq
  import hbd_pkg::*;
#(
  parameter int DLY_CYC = 2,
  parameter int WD_CYC  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_high,
  input  logic cmd_off,
  input  logic sup_rise,
  input  logic sup_fall,
  input  logic lg_low_fb,
  input  logic hg_low_fb,
  input  logic sw_low_fb,
  output logic hi_gate_en,
  output logic lo_gate_en,
  output logic pre_clamp,
  output logic wd_fault
);
  localparam int CW = cnt_width(DLY_CYC, WD_CYC);

  logic          por_up;
  logic          tmr_clr;
  logic [CW-1:0] tmr_cnt;

  hbd_supply_por u_por (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (sup_rise),
    .fall_i  (sup_fall),
    .up_o    (por_up),
    .clamp_o (pre_clamp)
  );

  hbd_step_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (tmr_clr),
    .cnt_o (tmr_cnt)
  );

  hbd_gate_seq #(.DLY_CYC(DLY_CYC), .WD_CYC(WD_CYC), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_i      (por_up),
    .pwm_hi_i  (cmd_high),
    .pwm_off_i (cmd_off),
    .lg_low_i  (lg_low_fb),
    .hg_low_i  (hg_low_fb),
    .sw_low_i  (sw_low_fb),
    .cnt_i     (tmr_cnt),
    .clr_o     (tmr_clr),
    .hs_en_o   (hi_gate_en),
    .ls_en_o   (lo_gate_en),
    .fault_o   (wd_fault)
  );

  // R5
  clamp_blocks_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_clamp |-> !hi_gate_en);
  // R7
  supply_down_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_up |=> (!hi_gate_en && !lo_gate_en));

endmodule

// File: tb/hb_deadtime_seq_bench.sv
module hb_deadtime_seq_bench;
  localparam int DLY = 2;
  localparam int WD  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_high = 0, cmd_off = 0, sup_rise = 0, sup_fall = 0;
  logic lg_low_fb = 0, hg_low_fb = 0, sw_low_fb = 0;
  logic hi_gate_en, lo_gate_en, pre_clamp, wd_fault;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hb_deadtime_seq #(.DLY_CYC(DLY), .WD_CYC(WD)) u_hb_deadtime_seq (
    .clk(clk), .rst_n(rst_n), .cmd_high(cmd_high), .cmd_off(cmd_off),
    .sup_rise(sup_rise), .sup_fall(sup_fall), .lg_low_fb(lg_low_fb),
    .hg_low_fb(hg_low_fb), .sw_low_fb(sw_low_fb), .hi_gate_en(hi_gate_en),
    .lo_gate_en(lo_gate_en), .pre_clamp(pre_clamp), .wd_fault(wd_fault));

  // behavioural reference: modes as strings of intent
  localparam int M_IDLE = 0, M_LOW = 1, M_TO_HIGH = 2, M_HOLD = 3,
                 M_HIGH = 4, M_TO_LOW = 5, M_QUIET = 6, M_DEAD = 7;
  int  m_mode = M_IDLE;
  int  m_age  = 0;
  bit  m_up   = 0;
  bit  m_ever = 0;

  function automatic int advance(int mode, int age, bit up);
    if (mode == M_DEAD) return M_DEAD;
    if (!up) return M_IDLE;
    if (cmd_off) return M_QUIET;
    if (mode == M_IDLE || mode == M_QUIET) return cmd_high ? M_TO_HIGH : M_TO_LOW;
    if (cmd_high) begin
      if (mode == M_LOW || mode == M_TO_LOW) return M_TO_HIGH;
      if (mode == M_TO_HIGH) return lg_low_fb ? M_HOLD : (age >= WD - 1 ? M_DEAD : M_TO_HIGH);
      if (mode == M_HOLD) return (age >= DLY - 1) ? M_HIGH : M_HOLD;
      return mode;
    end
    if (mode == M_HIGH || mode == M_HOLD || mode == M_TO_HIGH) return M_TO_LOW;
    if (mode == M_TO_LOW)
      return (hg_low_fb || sw_low_fb) ? M_LOW : (age >= WD - 1 ? M_DEAD : M_TO_LOW);
    return mode;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = M_IDLE; m_age = 0; m_up = 0; m_ever = 0;
    end else begin
      int nxt;
      nxt = advance(m_mode, m_age, m_up);
      m_age = (nxt == m_mode) ? m_age + 1 : 0;
      m_mode = nxt;
      if (sup_fall) m_up = 0;
      else if (sup_rise) m_up = 1;
      if (m_up) m_ever = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    chk("R1 overlap", int'(hi_gate_en & lo_gate_en), 0);
    chk("R2 model hi_gate_en", int'(hi_gate_en), int'(m_mode == M_HIGH));
    chk("R4 model lo_gate_en", int'(lo_gate_en), int'(m_mode == M_LOW));
    chk("R5 model pre_clamp", int'(pre_clamp), int'(!m_ever));
    chk("R10 model wd_fault", int'(wd_fault), int'(m_mode == M_DEAD));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R5 reset clamp", int'(pre_clamp), 1);
    chk("R10 reset fault", int'(wd_fault), 0);
    rst_n = 1'b1;
    // R5: command without supply
    cmd_high = 1;
    repeat (4) cycle();
    chk("R5 hs held before supply", int'(hi_gate_en), 0);
    chk("R5 clamp held", int'(pre_clamp), 1);
    // R6: supply up
    cmd_high = 0; sup_rise = 1;
    cycle();
    sup_rise = 0;
    chk("R6 clamp released", int'(pre_clamp), 0);
    hg_low_fb = 1;
    cycle(); cycle();
    chk("R4 ls on after hg flag", int'(lo_gate_en), 1);
    // R2 / R3
    hg_low_fb = 0; cmd_high = 1;
    cycle();
    chk("R2 ls dropped", int'(lo_gate_en), 0);
    repeat (5) cycle();
    chk("R2 hs waits for lg flag", int'(hi_gate_en), 0);
    lg_low_fb = 1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      cycle(); n++;
      if (hi_gate_en) break;
    end
    chk("R3 delay edges", n, DLY + 1);
    // R4 via switch-node flag only
    lg_low_fb = 0; cmd_high = 0;
    cycle();
    chk("R4 hs dropped", int'(hi_gate_en), 0);
    repeat (3) cycle();
    chk("R4 ls waits", int'(lo_gate_en), 0);
    sw_low_fb = 1;
    cycle();
    chk("R4 sw flag releases ls", int'(lo_gate_en), 1);
    sw_low_fb = 0;
    // R9 reversal during wait
    cmd_high = 1;
    repeat (3) cycle();
    cmd_high = 0; hg_low_fb = 1;
    cycle();
    chk("R9 no early enable hs", int'(hi_gate_en), 0);
    chk("R9 no early enable ls", int'(lo_gate_en), 0);
    cycle();
    chk("R9 restarted low", int'(lo_gate_en), 1);
    // R9 reversal during delay
    hg_low_fb = 0; cmd_high = 1; lg_low_fb = 1;
    cycle(); cycle();
    cmd_high = 0; lg_low_fb = 0;
    cycle();
    chk("R9 delay cancelled", int'(hi_gate_en), 0);
    hg_low_fb = 1;
    cycle();
    chk("R9 low after cancel", int'(lo_gate_en), 1);
    hg_low_fb = 0;
    // R8 shutdown
    cmd_off = 1;
    cycle();
    chk("R8 ls off in shutdown", int'(lo_gate_en), 0);
    cmd_high = 1;
    repeat (3) cycle();
    chk("R8 hs off in shutdown", int'(hi_gate_en), 0);
    cmd_off = 0; lg_low_fb = 1;
    repeat (DLY + 3) cycle();
    chk("R8 resume", int'(hi_gate_en), 1);
    // R7 supply drop
    sup_fall = 1;
    cycle();
    sup_fall = 0;
    cycle();
    chk("R7 hs off after drop", int'(hi_gate_en), 0);
    chk("R7 clamp stays off", int'(pre_clamp), 0);
    sup_rise = 1; sup_fall = 1;
    cycle();
    sup_rise = 0; sup_fall = 0;
    cycle();
    chk("R6 fall wins", int'(hi_gate_en), 0);
    sup_rise = 1;
    cycle();
    sup_rise = 0;
    repeat (DLY + 4) cycle();
    chk("R6 re-enabled", int'(hi_gate_en), 1);
    chk("R7 clamp not re-armed", int'(pre_clamp), 0);
    // R10 watchdog
    cmd_high = 0; lg_low_fb = 0; hg_low_fb = 0; sw_low_fb = 0;
    repeat (WD + 3) cycle();
    chk("R10 fault set", int'(wd_fault), 1);
    cmd_high = 1; lg_low_fb = 1; hg_low_fb = 1;
    repeat (6) cycle();
    chk("R10 fault sticky", int'(wd_fault), 1);
    chk("R10 hs held off", int'(hi_gate_en), 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    cmd_high = 0; lg_low_fb = 0; hg_low_fb = 0;
    cycle();
    chk("R10 fault cleared by reset", int'(wd_fault), 0);
    chk("R5 clamp re-armed by reset", int'(pre_clamp), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule